// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the command interface of a parallel NOR-style flash memory as synchronous logic. It watches the active-low chip enable, write enable and output enable strobes with the address and data buses. It follows the two-write unlock preamble and acts on the command byte that comes after it. The commands cover program, erase (of sectors or of the whole array), the ID-code mode, and a fast-program mode that drops the unlock preamble for each word.

The storage is a small array of 16-bit words that resets to all ones. A program takes a fixed number of clock cycles. An erase first waits through a collection window and then takes a fixed number of clock cycles. While either one runs, reads return a status byte instead of array data. An erase can be suspended and then resumed. A byte/word input sets how addresses and program data are interpreted.

Top module: `flash_cmd_seq`

## Requirements
- R1: A bus cycle is a command write only when ce_n and we_n are both low and oe_n is high. A cycle with oe_n low or ce_n high has no effect on the sequencer.
- R2: The array resets to all ones (0xFFFF per word). A normal program is four writes: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the data at the target address. The stored word becomes the old word AND the data, so a program can only clear bits.
- R3: If a write in the unlock preamble or its command step has the wrong address or data, the sequencer returns to array read. The following write is treated as a fresh command, so no program happens.
- R4: The unlock preamble followed by 0x20 at 0x555 enters fast-program mode. In that mode a program is two writes: 0xA0 at any address, then the data. The block stays in fast-program mode after each program, and array reads work in that mode.
- R5: A write of 0xF0 returns the block to array read from ID mode, from fast-program mode or from a partial preamble. After fast-program mode is left this way, a lone 0xA0 plus data write programs nothing.
- R6: The preamble followed by 0x90 at 0x555 enters ID mode. Reads then return the maker code at word offset 0, the device code at offset 1 and zero at other offsets. The code sits in bits 7:0 and bits 15:8 are zero.
- R7: While a program runs, busy is high for exactly PROG_CYC cycles after the data write. A read returns bit 7 equal to the complement of bit 7 of the data being programmed, bit 6 equal to a flag that inverts on every status read, and all other bits zero.
- R8: The erase preamble is the unlock preamble, 0x80 at 0x555, then the unlock preamble again. After that, 0x30 at an address starts a sector erase of that sector. The sector is the top SBITS bits of the word index. Further 0x30 writes inside the window add their sectors and restart the window. The window lasts WIN_CYC cycles and is followed by ERASE_CYC cycles of erase, so a single-sector erase holds busy for WIN_CYC+ERASE_CYC cycles. Only the selected sectors become all ones. Status reads in the window and during the erase show bit 7 low.
- R9: After the erase preamble, 0x10 at 0x555 erases the whole array at once, with no window, and holds busy for ERASE_CYC cycles.
- R10: During an erase, 0xB0 suspends it. Busy drops and reads return unchanged array data. A later 0x30 resumes the erase. The total number of busy cycles stays ERASE_CYC.
- R11: When word_mode is 0, address bit 0 picks the byte within word addr[ABITS:1], with 1 meaning the upper byte. Program data is taken from wdata[7:0] only. Reads return that byte in bits 7:0 with bits 15:8 zero.
- R12: While a program runs, every write is ignored, including 0xF0 and preamble bytes. After the program ends the block is in array read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| addr | input | AW | Bus address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data; zero outside a read cycle |
| busy | output | 1 | High during an erase window, a program or an erase |

## Verification
The checks assume that each bus cycle holds its strobes for at least one full clock and that an idle clock separates it from the next cycle, because both writes and reads are counted on the first clock of the strobe. They also assume that a read cycle and a write cycle never overlap. The stimulus tasks drive each cycle for exactly one clock and then release it for a clock. Suspend is issued only a few cycles into an erase, so the erase counter is still nonzero when it arrives.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 11,
  parameter int ABITS = 4,
  parameter int SBITS = 2,
  parameter int PROG_CYC = 8,
  parameter int WIN_CYC = 6,
  parameter int ERASE_CYC = 20,
  parameter logic [7:0] MFG_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'hC4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          busy
);
  localparam int WORDS = 1 << ABITS;
  localparam int SECTS = 1 << SBITS;
  localparam int SH = ABITS - SBITS;
  localparam int CW = $clog2(PROG_CYC + WIN_CYC + ERASE_CYC + 1);

  localparam logic [3:0] S_RD = 4'd0, S_U1 = 4'd1, S_U2 = 4'd2, S_PG = 4'd3,
                         S_ES = 4'd4, S_EU1 = 4'd5, S_EU2 = 4'd6, S_EW = 4'd7,
                         S_AS = 4'd8, S_BY = 4'd9, S_BP = 4'd10, S_BSYP = 4'd11,
                         S_BSYE = 4'd12, S_SUS = 4'd13;

  logic [3:0]       st;
  logic [CW-1:0]    cnt;
  logic [15:0]      mem [WORDS];
  logic             wr_q, rd_q, tog, p_b7, ret_byp;
  logic [ABITS-1:0] p_idx;
  logic [15:0]      p_dat;
  logic [SECTS-1:0] emask;

  logic wr_c, rd_c, wr, rd_go, at_a, at_b, f0_ok;
  logic [7:0] cmd, id;
  logic [ABITS-1:0] idx;
  logic [SBITS-1:0] wsec;
  logic [15:0] word, arr, stat, pd;

  assign wr_c  = ~ce_n & ~we_n & oe_n;
  assign rd_c  = ~ce_n & ~oe_n & we_n;
  assign wr    = wr_c & ~wr_q;
  assign rd_go = rd_c & ~rd_q;
  assign cmd   = wdata[7:0];
  assign at_a  = addr[10:0] == 11'h555;
  assign at_b  = addr[10:0] == 11'h2AA;
  assign idx   = word_mode ? addr[ABITS-1:0] : addr[ABITS:1];
  assign wsec  = idx[ABITS-1 -: SBITS];
  assign busy  = (st == S_EW) | (st == S_BSYP) | (st == S_BSYE);
  assign f0_ok = ~busy & (st != S_SUS) & (st != S_PG) & (st != S_BP);

  assign pd   = word_mode ? wdata : (addr[0] ? {wdata[7:0], 8'hFF} : {8'hFF, wdata[7:0]});
  assign word = mem[idx];
  assign arr  = word_mode ? word : {8'h00, addr[0] ? word[15:8] : word[7:0]};
  assign stat = {8'h00, (st == S_BSYP) ? ~p_b7 : 1'b0, tog, 6'b0};
  assign id   = (addr[1:0] == 2'd0) ? MFG_ID : (addr[1:0] == 2'd1) ? DEV_ID : 8'h00;
  assign rdata = ~rd_c ? 16'h0000 : busy ? stat : (st == S_AS) ? {8'h00, id} : arr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RD;
      cnt <= '0;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      tog <= 1'b0;
      p_b7 <= 1'b0;
      ret_byp <= 1'b0;
      p_idx <= '0;
      p_dat <= '1;
      emask <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      wr_q <= wr_c;
      rd_q <= rd_c;
      if (rd_go && busy) tog <= ~tog;
      if (wr && cmd == 8'hF0 && f0_ok) st <= S_RD;
      else begin
        case (st)
          S_RD:  if (wr) st <= (at_a && cmd == 8'hAA) ? S_U1 : S_RD;
          S_U1:  if (wr) st <= (at_b && cmd == 8'h55) ? S_U2 : S_RD;
          S_U2:  if (wr) begin
                   st <= S_RD;
                   if (at_a) begin
                     case (cmd)
                       8'hA0: st <= S_PG;
                       8'h80: st <= S_ES;
                       8'h90: st <= S_AS;
                       8'h20: st <= S_BY;
                       default: ;
                     endcase
                   end
                 end
          S_PG, S_BP: if (wr) begin
                   p_idx <= idx;
                   p_dat <= pd;
                   p_b7 <= wdata[7];
                   ret_byp <= (st == S_BP);
                   cnt <= CW'(PROG_CYC - 1);
                   st <= S_BSYP;
                 end
          S_ES:  if (wr) st <= (at_a && cmd == 8'hAA) ? S_EU1 : S_RD;
          S_EU1: if (wr) st <= (at_b && cmd == 8'h55) ? S_EU2 : S_RD;
          S_EU2: if (wr) begin
                   if (at_a && cmd == 8'h10) begin
                     emask <= '1;
                     cnt <= CW'(ERASE_CYC - 1);
                     st <= S_BSYE;
                   end else if (cmd == 8'h30) begin
                     emask <= '0;
                     emask[wsec] <= 1'b1;
                     cnt <= CW'(WIN_CYC - 1);
                     st <= S_EW;
                   end else st <= S_RD;
                 end
          S_EW:  if (wr) begin
                   if (cmd == 8'h30) begin
                     emask[wsec] <= 1'b1;
                     cnt <= CW'(WIN_CYC - 1);
                   end else st <= S_RD;
                 end else if (cnt == '0) begin
                   cnt <= CW'(ERASE_CYC - 1);
                   st <= S_BSYE;
                 end else cnt <= cnt - 1'b1;
          S_AS:  ;
          S_BY:  if (wr && cmd == 8'hA0) st <= S_BP;
          S_BSYP: if (cnt == '0) begin
                   mem[p_idx] <= mem[p_idx] & p_dat;
                   st <= ret_byp ? S_BY : S_RD;
                 end else cnt <= cnt - 1'b1;
          S_BSYE: if (cnt == '0) begin
                   for (int i = 0; i < WORDS; i++)
                     if (emask[SBITS'(i >> SH)]) mem[i] <= '1;
                   st <= S_RD;
                 end else begin
                   cnt <= cnt - 1'b1;
                   if (wr && cmd == 8'hB0) st <= S_SUS;
                 end
          S_SUS: if (wr && cmd == 8'h30) st <= S_BSYE;
          default: st <= S_RD;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [10:0]   ua,
  input logic [7:0]    cmd,
  input logic [15:0]   rdata,
  input logic [3:0]    st,
  input logic [CW-1:0] cnt
);
  localparam logic [3:0] S_RD = 4'd0, S_U1 = 4'd1, S_EW = 4'd7, S_AS = 4'd8,
                         S_BSYP = 4'd11, S_BSYE = 4'd12, S_SUS = 4'd13;

  logic wq, wcond, rcond, wedge;
  assign wcond = ~ce_n & ~we_n & oe_n;
  assign rcond = ~ce_n & ~oe_n & we_n;
  assign wedge = wcond & ~wq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wq <= 1'b0;
    else wq <= wcond;

  AST_IDLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_RD && !wcond) |=> st == S_RD); // R1
  AST_UNLOCK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n) (st == S_U1 && wedge && !(ua == 11'h2AA && cmd == 8'h55)) |=> st == S_RD); // R3
  AST_ID_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (st == S_AS && rcond) |-> rdata[15:8] == 8'h00); // R6
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_BSYP && rcond) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'd0)); // R7
  AST_WINDOW_TO_ERASE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_EW && cnt == '0 && !wedge) |=> st == S_BSYE); // R8
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) st == S_SUS |=> $stable(cnt)); // R10
  AST_PROG_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n) (st == S_BSYP && cnt != '0) |=> st == S_BSYP); // R12
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .ua(addr[10:0]), .cmd(wdata[7:0]), .rdata(rdata), .st(st), .cnt(cnt)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int PROG_CYC = 8, WIN_CYC = 6, ERASE_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy;

  flash_cmd_seq #(.PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .word_mode(word_mode), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, bc = 0;
  logic tog = 1'b0;
  logic [15:0] expm [16];
  logic [15:0] v;

  always @(posedge clk) if (busy) bc++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input logic c, input logic w, input logic o, input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = c; we_n = w; oe_n = o;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    wr_raw(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] q);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 q = rdata;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unl();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    unl();
    wr(11'h555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd(11'(i), v);
      check(tag, v, expm[i]);
    end
  endtask

  function automatic logic [15:0] pat1(input int i);
    return 16'(i * 4951) ^ 16'hBEEF;
  endfunction

  function automatic logic [15:0] pat2(input int i);
    return 16'(i * 7919) ^ 16'h7A5D;
  endfunction

  function automatic logic [15:0] stw(input logic b7, input logic t);
    return {8'h00, b7, t, 6'b0};
  endfunction

  initial begin
    #(5 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) expm[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset busy", {15'd0, busy}, 16'd0);
    check("R2 reset idle rdata", rdata, 16'h0000);
    verify_all("R2 reset array");

    // R2 R7 R12: normal program pass
    for (int i = 0; i < 16; i++) begin
      bc = 0;
      prog(11'(i), pat1(i));
      if (i == 0) begin
        for (int k = 0; k < 3; k++) begin
          rd(11'd7, v);
          check("R7 program status", v, stw(~pat1(0)[7], tog));
          tog = ~tog;
        end
      end
      if (i == 2) begin
        wr(11'h000, 16'h00F0);
        wr(11'h555, 16'h00AA);
      end
      idle();
      if (i == 1) check("R7 program busy cycles", 16'(bc), 16'(PROG_CYC));
      if (i == 2) check("R12 busy ignores writes", 16'(bc), 16'(PROG_CYC));
      expm[i] = expm[i] & pat1(i);
    end
    verify_all("R2 program pass");

    // R4 fast program, AND with previous content
    unl();
    wr(11'h555, 16'h0020);
    for (int i = 0; i < 16; i++) begin
      bc = 0;
      wr(11'h3F0, 16'h00A0);
      wr(11'(i), pat2(i));
      idle();
      if (i == 5) check("R4 fast program busy", 16'(bc), 16'(PROG_CYC));
      expm[i] = expm[i] & pat2(i);
      if (i == 0) begin
        rd(11'd0, v);
        check("R4 read in fast mode", v, expm[0]);
      end
    end
    wr(11'h000, 16'h00F0);
    verify_all("R4 fast program pass");

    // R5 lone A0 after leaving fast mode
    wr(11'h000, 16'h00A0);
    wr(11'd3, 16'h0000);
    check("R5 no program after exit", {15'd0, busy}, 16'd0);
    idle();
    rd(11'd3, v);
    check("R5 word untouched", v, expm[3]);

    // R8 multi-sector erase: sectors 1 and 3
    unl(); wr(11'h555, 16'h0080); unl();
    wr(11'd4, 16'h0030);
    wr(11'd13, 16'h0030);
    idle();
    for (int i = 4; i < 8; i++) expm[i] = 16'hFFFF;
    for (int i = 12; i < 16; i++) expm[i] = 16'hFFFF;
    verify_all("R8 multi-sector erase");

    // R8 single sector with status read
    bc = 0;
    unl(); wr(11'h555, 16'h0080); unl();
    wr(11'd1, 16'h0030);
    rd(11'd1, v);
    check("R8 erase status", v, stw(1'b0, tog));
    tog = ~tog;
    idle();
    check("R8 single sector busy cycles", 16'(bc), 16'(WIN_CYC + ERASE_CYC));
    for (int i = 0; i < 4; i++) expm[i] = 16'hFFFF;
    verify_all("R8 single sector erase");

    // R11 byte mode
    word_mode = 1'b0;
    prog(11'd5, 16'hAB3C);
    idle();
    prog(11'd4, 16'h1281);
    idle();
    expm[2] = 16'h3C81;
    rd(11'd5, v);
    check("R11 upper byte read", v, 16'h003C);
    rd(11'd4, v);
    check("R11 lower byte read", v, 16'h0081);
    word_mode = 1'b1;
    rd(11'd2, v);
    check("R11 word view", v, 16'h3C81);

    // R6 ID mode, R5 exit
    unl(); wr(11'h555, 16'h0090);
    rd(11'd0, v); check("R6 maker code", v, 16'h0001);
    rd(11'd1, v); check("R6 device code", v, 16'h00C4);
    rd(11'd2, v); check("R6 other offset", v, 16'h0000);
    wr(11'h000, 16'h00F0);
    rd(11'd9, v); check("R5 array after ID exit", v, expm[9]);

    // R9 chip erase, R10 suspend/resume
    bc = 0;
    unl(); wr(11'h555, 16'h0080); unl();
    wr(11'h555, 16'h0010);
    check("R9 chip erase busy", {15'd0, busy}, 16'd1);
    wr(11'h000, 16'h00B0);
    check("R10 suspended not busy", {15'd0, busy}, 16'd0);
    rd(11'd9, v); check("R10 read while suspended", v, expm[9]);
    rd(11'd2, v); check("R10 read while suspended", v, expm[2]);
    wr(11'h000, 16'h0030);
    idle();
    check("R10 total erase cycles", 16'(bc), 16'(ERASE_CYC));
    for (int i = 0; i < 16; i++) expm[i] = 16'hFFFF;
    verify_all("R9 chip erase");

    // R1 strobe qualification
    wr_raw(1'b0, 1'b0, 1'b0, 11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h00A0);
    wr(11'd9, 16'h0000);
    check("R1 oe low not a write", {15'd0, busy}, 16'd0);
    idle();
    rd(11'd9, v); check("R1 word untouched", v, 16'hFFFF);
    unl();
    wr_raw(1'b1, 1'b0, 1'b1, 11'h555, 16'h00A0);
    wr(11'd9, 16'h0000);
    idle();
    rd(11'd9, v); check("R1 ce high not a write", v, 16'hFFFF);

    // R3 mismatches
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0056);
    wr(11'h555, 16'h00A0);
    wr(11'd9, 16'h0000);
    idle();
    rd(11'd9, v); check("R3 bad data step", v, 16'hFFFF);
    unl();
    wr(11'h554, 16'h00A0);
    wr(11'd9, 16'h0000);
    idle();
    rd(11'd9, v); check("R3 bad command address", v, 16'hFFFF);
    prog(11'd9, 16'h1234);
    idle();
    rd(11'd9, v); check("R3 recovery program", v, 16'h1234);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule